// File: doc/BRIEF.md
# Two-Way Microsequenced Control Unit

This block is the control section of a small special-purpose processor, built as an ordinary synchronous sequential circuit. A state register holds the current microstate. A read-only table, indexed by that state, yields one wide word. The word carries the control word that drives the datapath during the current cycle and two candidate successor states. A selector steered by the datapath's zero flag picks the successor that the register loads at the next clock edge.

The table is read without a register in the path. The control word is therefore valid in the same cycle that a state becomes current, and it depends on the state alone (Moore behaviour). A state whose two successor fields hold the same value is an unconditional step. The default microprogram is computed at elaboration from a rule in the shared package. The table can be built either as a constant array or as logic evaluated directly from the state. Widths are parameters; the defaults are a 4-bit state and an 8-bit control word.

Top module: `msq_ctrl_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state` becomes 0 after that edge, whatever the value of `zero`.
- R2: `ctrl` is a function of the current `state` only, valid in the same cycle. For state s, bit i of `ctrl` equals bit (i mod STATE_W) of s, and that bit is inverted when i ≥ STATE_W. With the defaults this gives `ctrl = {~s, s}`. A change of `zero` within a cycle leaves `ctrl` unchanged.
- R3: In a conditional state (s mod 4 ≠ 3), `zero` = 1 at the edge loads the successor (s + 6) mod 2^STATE_W.
- R4: In a conditional state, `zero` = 0 at the edge loads the successor (s + 1) mod 2^STATE_W.
- R5: In states 3, 7 and 11, both successor fields hold s + 1, so the step is unconditional and `zero` has no effect on it.
- R6: The last state (all ones) is unconditional and returns to state 0 for either value of `zero`.
- R7: Each table word is packed as {successor when zero = 1, successor when zero = 0, control word}, 2·STATE_W + CTRL_W bits wide. Both table variants (constant array and direct logic) produce identical words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| zero | input | 1 | Zero condition bit from the datapath; steers the successor choice |
| state | output | STATE_W | Current microstate |
| ctrl | output | CTRL_W | Control word for the current cycle |

## Verification
The embedded properties check every transition on every cycle: the return to 0 after reset, the +6 and +1 successors of conditional states, the +1 step of unconditional states, the wrap from the last state to 0, and that `ctrl` does not move while `state` holds. The scoreboard covers what those properties cannot fix alone. It confirms the exact control-word values of each visited state, that reset takes priority over a raised zero flag, and that long walks under several zero-flag patterns follow the expected path through all sixteen states, including the wrap.

// File: rtl/msq_pkg.sv
package msq_pkg;

   localparam int MSQ_MAX_CTRL_W = 64;

   // Unconditional microstates: low two bits both set
   function automatic bit msq_is_uncond(int s);
      return (s % 4) == 3;
   endfunction

   // Successor taken when the zero flag is low
   function automatic int msq_succ_lo(int s, int sw);
      return (s + 1) % (1 << sw);
   endfunction

   // Successor taken when the zero flag is high
   function automatic int msq_succ_hi(int s, int sw);
      return msq_is_uncond(s) ? msq_succ_lo(s, sw) : (s + 6) % (1 << sw);
   endfunction

   // Control image: state bits repeated, upper copies inverted
   function automatic logic [MSQ_MAX_CTRL_W-1:0] msq_ctrl_image(int s, int sw, int cw);
      logic [MSQ_MAX_CTRL_W-1:0] v;
      v = '0;
      for (int i = 0; i < cw; i++) begin
         v[i] = s[i % sw] ^ (i >= sw);
      end
      return v;
   endfunction

endpackage

// File: rtl/msq_state_reg.sv
module msq_state_reg #(
   parameter int STATE_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [STATE_W-1:0] nxt,
   output logic [STATE_W-1:0] state
);

   always_ff @(posedge clk) begin
      if (rst) state <= '0;
      else     state <= nxt;
   end

   // R1: reset drives the register to state 0
   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (state == '0))
      else $error("reset did not clear state");

endmodule

// File: rtl/msq_rom.sv
module msq_rom #(
   parameter int STATE_W      = 4,
   parameter int CTRL_W       = 8,
   parameter bit ROM_AS_TABLE = 1'b1
) (
   input  logic [STATE_W-1:0]          addr,
   output logic [2*STATE_W+CTRL_W-1:0] word
);
   import msq_pkg::*;

   localparam int DEPTH  = 1 << STATE_W;
   localparam int WORD_W = 2*STATE_W + CTRL_W;

   function automatic logic [WORD_W-1:0] entry(int s);
      logic [STATE_W-1:0]        hi_s;
      logic [STATE_W-1:0]        lo_s;
      logic [MSQ_MAX_CTRL_W-1:0] img;
      hi_s = STATE_W'(msq_succ_hi(s, STATE_W));
      lo_s = STATE_W'(msq_succ_lo(s, STATE_W));
      img  = msq_ctrl_image(s, STATE_W, CTRL_W);
      return {hi_s, lo_s, img[CTRL_W-1:0]};
   endfunction

   generate
      if (ROM_AS_TABLE) begin : g_array
         logic [WORD_W-1:0] rom_q [DEPTH];
         for (genvar g = 0; g < DEPTH; g++) begin : g_word
            assign rom_q[g] = entry(g);
         end
         assign word = rom_q[addr];
      end else begin : g_logic
         assign word = entry(int'(addr));
      end
   endgenerate

endmodule

// File: rtl/msq_next_mux.sv
module msq_next_mux #(
   parameter int STATE_W = 4
) (
   input  logic               zero,
   input  logic [STATE_W-1:0] succ_hi,
   input  logic [STATE_W-1:0] succ_lo,
   output logic [STATE_W-1:0] nxt
);

   always_comb begin
      nxt = zero ? succ_hi : succ_lo;
   end

endmodule

// File: rtl/msq_ctrl_unit.sv
module msq_ctrl_unit #(
   parameter int STATE_W      = 4,
   parameter int CTRL_W       = 8,
   parameter bit ROM_AS_TABLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               zero,
   output logic [STATE_W-1:0] state,
   output logic [CTRL_W-1:0]  ctrl
);

   localparam int WORD_W = 2*STATE_W + CTRL_W;
   localparam int CTRL_LSB = 0;
   localparam int LO_LSB   = CTRL_W;
   localparam int HI_LSB   = CTRL_W + STATE_W;
   localparam logic [STATE_W-1:0] STEP = STATE_W'(1);
   localparam logic [STATE_W-1:0] JUMP = STATE_W'(6);
   localparam logic [STATE_W-1:0] LAST = '1;

   generate
      if (STATE_W < 3 || STATE_W > 8) begin : g_bad_state_w
         $error("STATE_W must lie in 3..8");
      end
      if (CTRL_W < STATE_W || CTRL_W > msq_pkg::MSQ_MAX_CTRL_W) begin : g_bad_ctrl_w
         $error("CTRL_W must lie in STATE_W..64");
      end
   endgenerate

   logic [WORD_W-1:0]  rom_word;
   logic [STATE_W-1:0] succ_hi;
   logic [STATE_W-1:0] succ_lo;
   logic [STATE_W-1:0] nxt;

   msq_state_reg #(.STATE_W(STATE_W)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .nxt   (nxt),
      .state (state)
   );

   msq_rom #(
      .STATE_W      (STATE_W),
      .CTRL_W       (CTRL_W),
      .ROM_AS_TABLE (ROM_AS_TABLE)
   ) u_rom (
      .addr (state),
      .word (rom_word)
   );

   // R7: word packing {successor on zero=1, successor on zero=0, control}
   assign succ_hi = rom_word[HI_LSB +: STATE_W];
   assign succ_lo = rom_word[LO_LSB +: STATE_W];
   assign ctrl    = rom_word[CTRL_LSB +: CTRL_W];

   msq_next_mux #(.STATE_W(STATE_W)) u_mux (
      .zero    (zero),
      .succ_hi (succ_hi),
      .succ_lo (succ_lo),
      .nxt     (nxt)
   );

   // R3: conditional state with zero high jumps ahead by six
   assert_cond_taken_R3: assert property (@(posedge clk) disable iff (rst)
      (state[1:0] != 2'b11 && zero) |=> (state == $past(state) + JUMP))
      else $error("taken successor wrong");

   // R4: conditional state with zero low steps by one
   assert_cond_fall_R4: assert property (@(posedge clk) disable iff (rst)
      (state[1:0] != 2'b11 && !zero) |=> (state == $past(state) + STEP))
      else $error("fall-through successor wrong");

   // R5: unconditional states step by one for either flag value
   assert_uncond_step_R5: assert property (@(posedge clk) disable iff (rst)
      (state[1:0] == 2'b11 && state != LAST) |=> (state == $past(state) + STEP))
      else $error("unconditional step wrong");

   // R6: last state wraps to zero
   assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (state == LAST) |=> (state == '0))
      else $error("last state did not wrap");

   // R2: control word is held while the state is held
   assert_ctrl_moore_R2: assert property (@(posedge clk) disable iff (rst)
      $stable(state) |-> $stable(ctrl))
      else $error("control word moved without a state change");

endmodule

// File: tb/sim_msq_ctrl_unit.sv
`timescale 1ns/1ps
module sim_msq_ctrl_unit;

   logic       clk  = 1'b0;
   logic       rst  = 1'b1;
   logic       zero = 1'b0;
   logic [3:0] state;
   logic [7:0] ctrl;

   int compared   = 0;
   int mismatched = 0;
   int cyc        = 0;

   typedef struct {
      int         due;
      logic [3:0] st;
      string      tag;
   } item_t;

   item_t      sb[$];
   logic [3:0] model_s = 4'd0;

   always #2 clk = ~clk;   // 250 MHz

   always @(posedge clk) cyc <= cyc + 1;

   msq_ctrl_unit u0 (
      .clk   (clk),
      .rst   (rst),
      .zero  (zero),
      .state (state),
      .ctrl  (ctrl)
   );

   // Independent successor model from R3..R6
   function automatic logic [3:0] exp_next(logic [3:0] s, logic z);
      if (s[1:0] == 2'b11) return s + 4'd1;      // R5, R6 (15+1 wraps to 0)
      return z ? s + 4'd6 : s + 4'd1;            // R3, R4
   endfunction

   task automatic drive(input logic r, input logic z);
      item_t it;
      @(posedge clk);
      #1;
      rst  = r;
      zero = z;
      if (r)                     it.tag = "R1";
      else if (model_s == 4'hF)  it.tag = "R6";
      else if (model_s[1:0] == 2'b11) it.tag = "R5";
      else if (z)                it.tag = "R3";
      else                       it.tag = "R4";
      model_s = r ? 4'd0 : exp_next(model_s, z);
      it.due  = cyc + 1;
      it.st   = model_s;
      sb.push_back(it);
   endtask

   // Monitor: compare at the falling edge once an item is due
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         it = sb.pop_front();
         compared++;
         if (state !== it.st) begin
            mismatched++;
            $display("FAIL %s state: got %h expected %h", it.tag, state, it.st);
         end
         compared++;
         if (ctrl !== {~it.st, it.st}) begin   // R2
            mismatched++;
            $display("FAIL R2 ctrl in state %h: got %h expected %h",
                     it.st, ctrl, {~it.st, it.st});
         end
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset, including with zero raised
      drive(1'b1, 1'b0);
      drive(1'b1, 1'b1);
      // R4, R5, R6: zero low walks all states and wraps
      for (int i = 0; i < 20; i++) drive(1'b0, 1'b0);
      // R3, R5: zero high
      for (int i = 0; i < 12; i++) drive(1'b0, 1'b1);
      // mixed pattern
      for (int i = 0; i < 30; i++) drive(1'b0, (i % 3) == 0);
      for (int i = 0; i < 30; i++) drive(1'b0, i[0]);
      // R1: reset in mid-run overrides zero
      drive(1'b1, 1'b1);
      // R5, R6: unconditional states with zero high reached via steps
      for (int i = 0; i < 16; i++) drive(1'b0, (i % 4) == 3 || i == 15);
      drive(1'b0, 1'b0);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule